// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a parameterized integer arithmetic and logic unit that computes a combinational result from a destination operand and a source operand. Alongside the result it keeps a registered set of four condition flags: carry, zero, sign and overflow. An execution stage presents an operation code, both operands and a shift-count choice. It reads the result in the same cycle. It raises a flag-write strobe when that operation should leave its condition codes behind for later conditional logic.

The operation set is:

- increment, decrement and negate of the destination;
- complement of the destination;
- add and subtract;
- bitwise xor, or and and;
- left shift, arithmetic right shift and logical right shift.

The shift distance can be a fixed one-bit step, an immediate byte, or the low byte of a count register. Only the low log2(WIDTH) bits of the selected count are used, so at the default width of 32 a count of 32 or more wraps modulo 32.

Carry reports unsigned overflow for additions and a borrow for subtractions. Overflow reports signed overflow: the carry into the top bit differs from the carry out of it. Logic operations clear carry and overflow. Shifts leave the last bit shifted out in carry.

Top module: `int_alu_flags`

## Requirements
- R1: Op codes 4 (add, D+S) and 0 (increment, D+1) give the low WIDTH bits of the sum on `result`; the carry computed for them is the carry out of bit WIDTH-1.
- R2: Op codes 5 (subtract, D-S), 1 (decrement, D-1) and 2 (negate, 0-D) give the wrapped difference; their carry is a borrow. For subtract the borrow is 1 when S > D unsigned, for decrement when D = 0, and for negate when D != 0.
- R3: For op codes 0, 1, 2, 4 and 5 the overflow computed is 1 exactly when the carry into bit WIDTH-1 differs from the carry out of it. For add this is the case when both operands share a sign and the result's sign differs from theirs.
- R4: The zero flag computed is 1 exactly when `result` is all zeros, whatever the carry or overflow. The sign flag computed equals `result[WIDTH-1]`.
- R5: Op codes 3 (~D), 6 (D^S), 7 (D|S) and 8 (D&S) give the bitwise result, with carry and overflow computed as 0.
- R6: Op codes 9 and 10 both shift D left, 11 shifts D right arithmetically and 12 shifts D right logically. The carry is the last bit shifted out and overflow is 0. A count of zero leaves D unchanged with carry 0.
- R7: The count select input `cnt_sel` chooses the shift count: 0 picks a count of 1, 1 picks `cnt_imm`, and 2 or 3 pick `cnt_reg`. Only the low log2(WIDTH) bits of the chosen byte are used.
- R8: On a rising clock edge with `flag_we` high, the four flag outputs take the values computed for the operation presented in that cycle. With `flag_we` low they hold, and an active-low reset clears them to 0.
- R9: Op codes 13 to 15 pass D to `result` with carry and overflow computed as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op | input | 4 | Operation code |
| dst | input | WIDTH | Destination operand D |
| src | input | WIDTH | Source operand S |
| cnt_sel | input | 2 | Shift count source select |
| cnt_imm | input | 8 | Immediate shift count |
| cnt_reg | input | 8 | Low byte of the count register |
| flag_we | input | 1 | Flag write strobe |
| result | output | WIDTH | Combinational result |
| cf | output | 1 | Registered carry/borrow flag |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |
| of | output | 1 | Registered overflow flag |

## Verification
Two functions can meet in one cycle: the combinational result of a new operation, and the flag register that still shows an earlier operation, or that is capturing the current one. The bench provokes this by issuing random operations with `flag_we` asserted about three times in four. Each cycle it checks `result` before the edge against the bench model. After the edge it checks the flags against a model that changes only on write cycles. Directed wraparound cases put carry, zero and overflow on the same edge (for example 0xFFFFFFFF+1 and 0x7FFFFFFF+1). A held-flag sequence shows that a stream of unwritten operations leaves the last captured flags in place.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_INC = 4'd0,
      OP_DEC = 4'd1,
      OP_NEG = 4'd2,
      OP_NOT = 4'd3,
      OP_ADD = 4'd4,
      OP_SUB = 4'd5,
      OP_XOR = 4'd6,
      OP_OR  = 4'd7,
      OP_AND = 4'd8,
      OP_SAL = 4'd9,
      OP_SHL = 4'd10,
      OP_SAR = 4'd11,
      OP_SHR = 4'd12
   } op_e;

   typedef enum logic [1:0] {
      CNT_ONE = 2'd0,
      CNT_IMM = 2'd1,
      CNT_REG = 2'd2,
      CNT_RG2 = 2'd3
   } cnt_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  op_e              op_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic [WIDTH-1:0] s_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cf_o,
   output logic             of_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] a_op, b_op;
   logic             cin, borrow_mode;
   logic [WIDTH-1:0] low_sum;
   logic [1:0]       top_sum;
   logic             c_into_msb;

   always_comb begin
      a_op        = d_i;
      b_op        = s_i;
      cin         = 1'b0;
      borrow_mode = 1'b0;
      unique case (op_i)
         OP_SUB: begin b_op = ~s_i;     cin = 1'b1; borrow_mode = 1'b1; end
         OP_INC: begin b_op = '0;       cin = 1'b1; end
         OP_DEC: begin b_op = '1;       borrow_mode = 1'b1; end
         OP_NEG: begin a_op = '0; b_op = ~d_i; cin = 1'b1; borrow_mode = 1'b1; end
         default: ;
      endcase
   end

   // split adder exposes the carry entering the top bit
   assign low_sum    = {1'b0, a_op[MSB-1:0]} + {1'b0, b_op[MSB-1:0]} + WIDTH'(cin);
   assign c_into_msb = low_sum[MSB];
   assign top_sum    = {1'b0, a_op[MSB]} + {1'b0, b_op[MSB]} + {1'b0, c_into_msb};

   assign res_o = {top_sum[0], low_sum[MSB-1:0]};
   assign cf_o  = top_sum[1] ^ borrow_mode;
   assign of_o  = top_sum[1] ^ c_into_msb;

   always_comb begin
      if (op_i == OP_ADD && of_o) begin
         // R3
         add_of_sign_chk: assert (d_i[MSB] == s_i[MSB] && res_o[MSB] != d_i[MSB])
            else $error("signed overflow flagged on add without sign rule");
      end
      if (op_i == OP_SUB) begin
         // R2
         sub_borrow_chk: assert (cf_o == (s_i > d_i))
            else $error("subtract borrow disagrees with unsigned compare");
      end
   end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  op_e              op_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic [WIDTH-1:0] s_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_NOT:  res_o = ~d_i;
         OP_XOR:  res_o = d_i ^ s_i;
         OP_OR:   res_o = d_i | s_i;
         OP_AND:  res_o = d_i & s_i;
         default: res_o = d_i;
      endcase
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int SHIFT_IMPL = 1,
   localparam int KW        = $clog2(WIDTH)
) (
   input  op_e              op_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic [KW-1:0]    k_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   // left vector carries a spill bit on top, right vector on the bottom
   logic [WIDTH:0] left_v, right_v;
   logic           fill;

   assign fill = (op_i == OP_SAR) & d_i[WIDTH-1];

   generate
      if (SHIFT_IMPL == 0) begin : g_operator
         logic [WIDTH:0] r_src;
         assign r_src  = {d_i, 1'b0};
         assign left_v = {1'b0, d_i} << k_i;
         always_comb begin
            if (fill) right_v = $unsigned($signed(r_src) >>> k_i);
            else      right_v = r_src >> k_i;
         end
      end else begin : g_staged
         logic [WIDTH:0] lst [KW+1];
         logic [WIDTH:0] rst [KW+1];
         assign lst[0] = {1'b0, d_i};
         assign rst[0] = {d_i, 1'b0};
         for (genvar i = 0; i < KW; i++) begin : g_stage
            localparam int SH = 1 << i;
            assign lst[i+1] = k_i[i] ? {lst[i][WIDTH-SH:0], {SH{1'b0}}} : lst[i];
            assign rst[i+1] = k_i[i] ? {{SH{fill}}, rst[i][WIDTH:SH]} : rst[i];
         end
         assign left_v  = lst[KW];
         assign right_v = rst[KW];
      end
   endgenerate

   always_comb begin
      if (op_i == OP_SAL || op_i == OP_SHL) begin
         res_o  = left_v[WIDTH-1:0];
         cout_o = left_v[WIDTH];
      end else begin
         res_o  = right_v[WIDTH:1];
         cout_o = right_v[0];
      end
   end

   always_comb begin
      if (k_i == '0) begin
         // R6
         zero_count_chk: assert (res_o == d_i && !cout_o)
            else $error("zero shift count altered the operand");
      end
   end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int SHIFT_IMPL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] dst,
   input  logic [WIDTH-1:0] src,
   input  logic [1:0]       cnt_sel,
   input  logic [7:0]       cnt_imm,
   input  logic [7:0]       cnt_reg,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic             cf,
   output logic             zf,
   output logic             sf,
   output logic             of
);
   localparam int KW = $clog2(WIDTH);

   generate
      if (WIDTH < 8 || WIDTH > 256 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("WIDTH must be a power of two from 8 to 256");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("SHIFT_IMPL must be 0 (operator) or 1 (staged)");
      end
   endgenerate

   op_e              op_q;
   logic [7:0]       cnt_byte;
   logic [KW-1:0]    k;
   logic             unused_cnt_hi;
   logic [WIDTH-1:0] as_res, bw_res, sh_res;
   logic             as_cf, as_of, sh_cf;
   logic             cf_n, of_n;

   assign op_q = op_e'(op);

   always_comb begin
      unique case (cnt_sel_e'(cnt_sel))
         CNT_ONE: cnt_byte = 8'd1;
         CNT_IMM: cnt_byte = cnt_imm;
         default: cnt_byte = cnt_reg;
      endcase
   end
   assign k             = cnt_byte[KW-1:0];
   assign unused_cnt_hi = ^cnt_byte[7:KW];

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .op_i(op_q), .d_i(dst), .s_i(src), .res_o(as_res), .cf_o(as_cf), .of_o(as_of)
   );

   alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .op_i(op_q), .d_i(dst), .s_i(src), .res_o(bw_res)
   );

   alu_shifter #(.WIDTH(WIDTH), .SHIFT_IMPL(SHIFT_IMPL)) u_shifter (
      .op_i(op_q), .d_i(dst), .k_i(k), .res_o(sh_res), .cout_o(sh_cf)
   );

   always_comb begin
      result = dst;
      cf_n   = 1'b0;
      of_n   = 1'b0;
      unique case (op_q)
         OP_INC, OP_DEC, OP_NEG, OP_ADD, OP_SUB: begin
            result = as_res; cf_n = as_cf; of_n = as_of;
         end
         OP_NOT, OP_XOR, OP_OR, OP_AND: result = bw_res;
         OP_SAL, OP_SHL, OP_SAR, OP_SHR: begin
            result = sh_res; cf_n = sh_cf;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cf <= 1'b0; zf <= 1'b0; sf <= 1'b0; of <= 1'b0;
      end else if (flag_we) begin
         cf <= cf_n;
         zf <= ~|result;
         sf <= result[WIDTH-1];
         of <= of_n;
      end
   end

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable({cf, zf, sf, of}))
      else $error("flags changed without write strobe");

   // R4
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (zf == ($past(result) == '0)) && (sf == $past(result[WIDTH-1])))
      else $error("zero/sign flag does not match captured result");

   // R5
   logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we && (op == 4'd3 || op == 4'd6 || op == 4'd7 || op == 4'd8) |=> !cf && !of)
      else $error("logic op left carry or overflow set");

   // R9
   spare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op >= 4'd13 |-> result == dst)
      else $error("spare op code did not pass destination");
endmodule

// File: tb/int_alu_flags_tb.sv
`timescale 1ns/1ps
module int_alu_flags_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op = '0;
   logic [W-1:0] dst = '0, src = '0;
   logic [1:0]   cnt_sel = '0;
   logic [7:0]   cnt_imm = '0, cnt_reg = '0;
   logic         flag_we = 1'b0;
   logic [W-1:0] result;
   logic         cf, zf, sf, of;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [3:0] exp_flags = 4'b0000;   // {cf,zf,sf,of}

   always #2.5 clk = ~clk;

   int_alu_flags #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .op(op), .dst(dst), .src(src),
      .cnt_sel(cnt_sel), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg),
      .flag_we(flag_we), .result(result), .cf(cf), .zf(zf), .sf(sf), .of(of)
   );

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd4:         return "R1";
         4'd1, 4'd2, 4'd5:   return "R2";
         4'd3, 4'd6, 4'd7, 4'd8: return "R5";
         4'd9, 4'd10, 4'd11, 4'd12: return "R6";
         default:            return "R9";
      endcase
   endfunction

   function automatic int count_of(input logic [1:0] sel, input logic [7:0] im,
                                   input logic [7:0] rg);
      // R7: select 0 -> 1, 1 -> immediate, 2/3 -> register byte, mod 32
      if (sel == 2'd0) return 1;
      if (sel == 2'd1) return int'(im) % W;
      return int'(rg) % W;
   endfunction

   // returns {cf, of, result}
   function automatic logic [W+1:0] model(input logic [3:0] o, input logic [W-1:0] d,
                                          input logic [W-1:0] s, input int k);
      logic [W:0]   t;
      logic [W-1:0] r;
      logic         c, v;
      r = d; c = 1'b0; v = 1'b0;
      case (o)
         4'd0: begin t = {1'b0, d} + 1; r = t[W-1:0]; c = t[W]; v = (d == 32'h7FFF_FFFF); end
         4'd1: begin r = d - 1; c = (d == 0); v = (d == 32'h8000_0000); end
         4'd2: begin r = -d; c = (d != 0); v = (d == 32'h8000_0000); end
         4'd3: r = ~d;
         4'd4: begin
            t = {1'b0, d} + {1'b0, s}; r = t[W-1:0]; c = t[W];
            v = (d[W-1] == s[W-1]) && (r[W-1] != d[W-1]);
         end
         4'd5: begin
            r = d - s; c = (s > d);
            v = (d[W-1] != s[W-1]) && (r[W-1] != d[W-1]);
         end
         4'd6: r = d ^ s;
         4'd7: r = d | s;
         4'd8: r = d & s;
         4'd9, 4'd10: begin r = d << k; c = (k != 0) ? d[W-k] : 1'b0; end
         4'd11: begin r = $unsigned($signed(d) >>> k); c = (k != 0) ? d[k-1] : 1'b0; end
         4'd12: begin r = d >> k; c = (k != 0) ? d[k-1] : 1'b0; end
         default: ;
      endcase
      return {c, v, r};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] o, input logic [W-1:0] d, input logic [W-1:0] s,
                         input logic [1:0] sel, input logic [7:0] im, input logic [7:0] rg,
                         input logic we);
      logic [W+1:0] m;
      int           k;
      @(negedge clk);
      op = o; dst = d; src = s; cnt_sel = sel; cnt_imm = im; cnt_reg = rg; flag_we = we;
      k = count_of(sel, im, rg);
      m = model(o, d, s, k);
      #1;
      check(req_of(o), "result", result, m[W-1:0]);
      @(posedge clk);
      // R4 zero/sign, R3 overflow, R8 capture only on write
      if (we) exp_flags = {m[W+1], (m[W-1:0] == 0), m[W-1], m[W]};
      #1;
      check(we ? "R3/R4/R8" : "R8", "flags{cf,zf,sf,of}",
            W'({cf, zf, sf, of}), W'(exp_flags));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pick [6];
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R8 reset clears flags
      check("R8", "reset flags", W'({cf, zf, sf, of}), '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 wrap: all ones plus one gives carry and zero, no overflow
      run_op(4'd4, 32'hFFFF_FFFF, 32'd1, 2'd0, 8'd0, 8'd0, 1'b1);
      // R3 positive overflow
      run_op(4'd4, 32'h7FFF_FFFF, 32'd1, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd0, 32'h7FFF_FFFF, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      // R2 borrow and signed overflow on subtract
      run_op(4'd5, 32'h8000_0000, 32'd1, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd5, 32'd3, 32'd5, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd2, 32'h8000_0000, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd2, 32'd0, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd1, 32'd0, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      // R5 logic clears carry/overflow after a carry-setting op
      run_op(4'd6, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 2'd0, 8'd0, 8'd0, 1'b1);
      // R6 both left-shift codes, count 32 wraps to 0 through R7 immediate
      run_op(4'd9,  32'h8000_0001, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd10, 32'h8000_0001, 32'd0, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd10, 32'hDEAD_BEEF, 32'd0, 2'd1, 8'd32, 8'd0, 1'b1);
      run_op(4'd11, 32'h8000_0000, 32'd0, 2'd2, 8'd0, 8'd31, 1'b1);
      run_op(4'd12, 32'h8000_0000, 32'd0, 2'd3, 8'd0, 8'd255, 1'b1);
      // R8 hold: set carry, then unwritten ops must not disturb it
      run_op(4'd4, 32'hFFFF_FFFF, 32'd2, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd8, 32'd0, 32'd0, 2'd0, 8'd0, 8'd0, 1'b0);
      run_op(4'd5, 32'd0, 32'd9, 2'd0, 8'd0, 8'd0, 1'b0);
      // R9 spare codes
      run_op(4'd13, 32'h1234_5678, 32'hFFFF_FFFF, 2'd0, 8'd0, 8'd0, 1'b1);
      run_op(4'd15, 32'd0, 32'd1, 2'd0, 8'd0, 8'd0, 1'b1);

      pick[0] = 32'd0; pick[1] = 32'd1; pick[2] = 32'h7FFF_FFFF;
      pick[3] = 32'h8000_0000; pick[4] = 32'hFFFF_FFFF; pick[5] = 32'h0;
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] a, b;
         a = ($urandom_range(0, 3) == 0) ? pick[$urandom_range(0, 4)] : $urandom;
         b = ($urandom_range(0, 3) == 0) ? pick[$urandom_range(0, 4)] : $urandom;
         run_op(4'($urandom_range(0, 15)), a, b, 2'($urandom_range(0, 3)),
                8'($urandom), 8'($urandom), ($urandom_range(0, 3) != 0));
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule